// File: doc/BRIEF.md
# Stencil Operand Feeder with Windowed Reuse

This block sits between an on-chip tile buffer and a stencil arithmetic pipeline. The tile is a cube of `EXT` points per side, held as one memory per Y plane, and each memory has two read ports. The feeder walks every centre point of the inner cube, which leaves a ghost margin of `RAD` points on every face. For each centre it delivers one operand vector that holds the centre value and the `2*RAD` axis neighbours along X, Y and Z. The default geometry is a 32-point tile, radius 4 and a 24-point inner cube, which gives 25 operands per vector.

Most points are read from the tile buffer only once. The feeder keeps a ring of `2*RAD+1` row buffers for the current plane. It picks one of three fetch modes from the centre position:
- LOAD fills a full `(2*RAD+1)`-square patch at the first centre of a plane.
- UPDATE slides along Z in the first row and fetches one new column of the window.
- REUSE, in all later rows, fetches only the newly entering row point. At the start of each row it first reads the ghost columns of that row.

Operands along Y come from the neighbouring plane memories, with one read each per vector, and all of those memories are read in parallel.

The controller is a state machine with these states:
- S_IDLE: waits for `start`.
- S_FETCH: issues up to two centre-plane reads per cycle, plus the Y-arm reads in its first cycle.
- S_DRAIN: the last read data lands in the row buffers.
- S_EMIT: holds `out_valid` until `out_ready`.
- S_DONE: a one-cycle completion pulse.

The transitions are:
- S_IDLE→S_FETCH on `start`.
- S_FETCH→S_DRAIN when the last pair of reads has been issued.
- S_DRAIN→S_EMIT unconditionally.
- S_EMIT→S_FETCH on accept of any vector but the last.
- S_EMIT→S_DONE on accept of the last vector.
- S_DONE→S_IDLE unconditionally.

Top module: `stencil_vec_feeder`

## Requirements
- R1: Each vector packs operands at `DW`-bit slots. Slot 0 is the centre (y,x,z). Slots 1..2R are X neighbours, slots 2R+1..4R are Y neighbours and slots 4R+1..6R are Z neighbours, where R=`RAD`. Within each arm, slot i holds offset i−R for i<R and offset i−R+1 otherwise. The read address for a point is `{row x, column z}`, and read data returns one cycle after the enable.
- R2: Centres run over RAD..EXT−1−RAD on every axis in Y-outer, X-middle, Z-inner order, each exactly once.
- R3: LOAD mode applies at the first centre of each plane (x=z=RAD). It makes (2R+1)² reads on the centre plane.
- R4: UPDATE mode applies to the other centres of the first row (x=RAD, z>RAD). It makes 2R+1 reads on the centre plane.
- R5: REUSE mode applies to all rows after the first. It makes one centre-plane read, or 2R+1 reads at z=RAD.
- R6: For every vector, each plane y±1..y±R gets exactly one port-A read. Planes farther away get none. Port B is used only on the centre plane.
- R7: While `out_valid` is high and `out_ready` is low, the vector holds steady and no reads are issued. No vector is lost or repeated.
- R8: `done` pulses for one cycle right after the last vector is accepted. After that, no reads or vectors occur until the next `start`.
- R9: During and after reset, `out_valid`, `done` and all read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass over the tile |
| rd_en_a | output | EXT | Port-A read enable per plane |
| rd_addr_a | output | EXT·2·clog2(EXT) | Port-A address {row, column} per plane |
| rd_data_a | input | EXT·DW | Port-A read data per plane, one-cycle latency |
| rd_en_b | output | EXT | Port-B read enable per plane |
| rd_addr_b | output | EXT·2·clog2(EXT) | Port-B address {row, column} per plane |
| rd_data_b | input | EXT·DW | Port-B read data per plane, one-cycle latency |
| out_valid | output | 1 | Operand vector available |
| out_ready | input | 1 | Pipeline accepts the vector |
| out_vec | output | (6·RAD+1)·DW | Packed operand vector |
| done | output | 1 | One-cycle pass-complete pulse |

## Verification
Some behaviours are checked on every cycle:
- the output holds under backpressure;
- no reads are issued while a vector waits;
- `done` lasts one cycle and is followed by idleness;
- at most 2R+1 planes are read per cycle, and port B is used on at most one plane.

Other behaviours can only be shown by the bench scenarios, which model the plane memories with a position-coded data pattern:
- the operand values and the visiting order;
- the per-vector read count for each of the three fetch modes;
- the one-read-per-vector rule for the neighbouring planes.

Two passes are run, one with the pipeline always ready and one with a pseudo-random ready pattern, so that mode changes meet stalls.

// File: rtl/svf_pkg.sv
package svf_pkg;

    typedef enum logic [1:0] {
        M_LOAD   = 2'd0,
        M_UPDATE = 2'd1,
        M_REUSE  = 2'd2
    } fmode_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_DRAIN = 3'd2,
        S_EMIT  = 3'd3,
        S_DONE  = 3'd4
    } fstate_e;

    // Signed offset of arm slot i for radius r, centre excluded.
    function automatic int arm_off(input int i, input int r);
        return (i < r) ? (i - r) : (i - r + 1);
    endfunction

endpackage

// File: rtl/svf_pick.sv
module svf_pick
    import svf_pkg::*;
#(
    parameter int RAD = 4,
    parameter int CW  = 5,
    parameter int KW  = 8
) (
    input  fmode_e          mode,
    input  logic [KW-1:0]   k,
    input  logic [CW-1:0]   cx,
    input  logic [CW-1:0]   cz,
    output logic [CW-1:0]   row,
    output logic [CW-1:0]   col
);
    localparam int W = 2 * RAD + 1;

    int ri;
    int ci;

    always_comb begin
        ri = 0;
        ci = 0;
        unique case (mode)
            M_LOAD: begin
                ri = int'(cx) - RAD + int'(k) / W;
                ci = int'(k) % W;
            end
            M_UPDATE: begin
                ri = int'(cx) - RAD + int'(k);
                ci = int'(cz) + RAD;
            end
            M_REUSE: begin
                ri = int'(cx) + RAD;
                ci = (int'(cz) == RAD) ? int'(k) : int'(cz) + RAD;
            end
            default: begin
                ri = 0;
                ci = 0;
            end
        endcase
        row = CW'(ri);
        col = CW'(ci);
    end

endmodule

// File: rtl/svf_window.sv
module svf_window
    import svf_pkg::*;
#(
    parameter int EXT = 32,
    parameter int RAD = 4,
    parameter int DW  = 32,
    parameter int CW  = 5,
    localparam int W    = 2 * RAD + 1,
    localparam int SW   = $clog2(W),
    localparam int NOPS = 6 * RAD + 1
) (
    input  logic                  clk,
    input  logic                  wa_en,
    input  logic [CW-1:0]         wa_row,
    input  logic [CW-1:0]         wa_col,
    input  logic [DW-1:0]         wa_data,
    input  logic                  wb_en,
    input  logic [CW-1:0]         wb_row,
    input  logic [CW-1:0]         wb_col,
    input  logic [DW-1:0]         wb_data,
    input  logic                  y_en,
    input  logic [2*RAD*DW-1:0]   y_data,
    input  logic [CW-1:0]         cx,
    input  logic [CW-1:0]         cz,
    output logic [NOPS*DW-1:0]    vec
);
    function automatic logic [SW-1:0] slot(input int r);
        return SW'(r % W);
    endfunction

    logic [DW-1:0] lb   [W][EXT];
    logic [DW-1:0] yarm [2*RAD];

    always_ff @(posedge clk) begin
        if (wa_en) lb[slot(int'(wa_row))][wa_col] <= wa_data;
        if (wb_en) lb[slot(int'(wb_row))][wb_col] <= wb_data;
    end

    for (genvar g = 0; g < 2 * RAD; g++) begin : g_yarm
        always_ff @(posedge clk) begin
            if (y_en) yarm[g] <= y_data[g*DW +: DW];
        end
    end

    always_comb begin
        vec = '0;
        vec[0 +: DW] = lb[slot(int'(cx))][cz];
        for (int i = 0; i < 2 * RAD; i++) begin
            vec[(1 + i) * DW +: DW] =
                lb[slot(int'(cx) + arm_off(i, RAD))][cz];
            vec[(1 + 2 * RAD + i) * DW +: DW] = yarm[i];
            vec[(1 + 4 * RAD + i) * DW +: DW] =
                lb[slot(int'(cx))][CW'(int'(cz) + arm_off(i, RAD))];
        end
    end

endmodule

// File: rtl/stencil_vec_feeder.sv
module stencil_vec_feeder
    import svf_pkg::*;
#(
    parameter int EXT = 32,
    parameter int RAD = 4,
    parameter int DW  = 32,
    localparam int CW   = $clog2(EXT),
    localparam int AW   = 2 * CW,
    localparam int W    = 2 * RAD + 1,
    localparam int NOPS = 6 * RAD + 1,
    localparam int KW   = $clog2(W * W + 2) + 1,
    localparam int LO   = RAD,
    localparam int HI   = EXT - 1 - RAD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic [EXT-1:0]       rd_en_a,
    output logic [EXT*AW-1:0]    rd_addr_a,
    input  logic [EXT*DW-1:0]    rd_data_a,
    output logic [EXT-1:0]       rd_en_b,
    output logic [EXT*AW-1:0]    rd_addr_b,
    input  logic [EXT*DW-1:0]    rd_data_b,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [NOPS*DW-1:0]   out_vec,
    output logic                 done
);
    fstate_e state, state_nx;
    fmode_e  mode;

    logic [CW-1:0] cy, cx, cz;
    logic [KW-1:0] k, cnt;
    logic [CW-1:0] row_a, col_a, row_b, col_b;
    logic          b_live, last_pair, last_ctr, accept;

    logic          pa_v, pb_v, py_v;
    logic [CW-1:0] pa_row, pa_col, pb_row, pb_col;
    logic [2*RAD*DW-1:0] y_data;

    // Mode and fetch count from centre position
    always_comb begin
        if (int'(cx) == LO && int'(cz) == LO) begin
            mode = M_LOAD;
            cnt  = KW'(W * W);
        end else if (int'(cx) == LO) begin
            mode = M_UPDATE;
            cnt  = KW'(W);
        end else begin
            mode = M_REUSE;
            cnt  = (int'(cz) == LO) ? KW'(W) : KW'(1);
        end
    end

    assign b_live    = (KW'(k + 1) < cnt);
    assign last_pair = (KW'(k + 2) >= cnt);
    assign last_ctr  = (int'(cy) == HI) && (int'(cx) == HI) && (int'(cz) == HI);
    assign accept    = (state == S_EMIT) && out_ready;

    svf_pick #(.RAD(RAD), .CW(CW), .KW(KW)) u_pick_a (
        .mode(mode), .k(k), .cx(cx), .cz(cz), .row(row_a), .col(col_a)
    );
    svf_pick #(.RAD(RAD), .CW(CW), .KW(KW)) u_pick_b (
        .mode(mode), .k(KW'(k + 1)), .cx(cx), .cz(cz), .row(row_b), .col(col_b)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_FETCH;
            S_FETCH: if (last_pair) state_nx = S_DRAIN;
            S_DRAIN: state_nx = S_EMIT;
            S_EMIT:  if (out_ready) state_nx = last_ctr ? S_DONE : S_FETCH;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = (state == S_EMIT);
        done      = (state == S_DONE);
        rd_en_a   = '0;
        rd_en_b   = '0;
        rd_addr_a = '0;
        rd_addr_b = '0;
        if (state == S_FETCH) begin
            rd_en_a[cy] = 1'b1;
            rd_addr_a[int'(cy) * AW +: AW] = {row_a, col_a};
            if (b_live) begin
                rd_en_b[cy] = 1'b1;
                rd_addr_b[int'(cy) * AW +: AW] = {row_b, col_b};
            end
            if (k == '0) begin
                for (int i = 0; i < 2 * RAD; i++) begin
                    rd_en_a[int'(cy) + arm_off(i, RAD)] = 1'b1;
                    rd_addr_a[(int'(cy) + arm_off(i, RAD)) * AW +: AW] = {cx, cz};
                end
            end
        end
    end

    // Y-arm data gather from neighbouring planes
    always_comb begin
        for (int i = 0; i < 2 * RAD; i++) begin
            y_data[i*DW +: DW] = rd_data_a[(int'(cy) + arm_off(i, RAD)) * DW +: DW];
        end
    end

    // Coordinates, fetch index and pending-read tags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cy <= CW'(LO); cx <= CW'(LO); cz <= CW'(LO);
            k  <= '0;
            pa_v <= 1'b0; pb_v <= 1'b0; py_v <= 1'b0;
            pa_row <= '0; pa_col <= '0; pb_row <= '0; pb_col <= '0;
        end else begin
            pa_v   <= (state == S_FETCH);
            pb_v   <= (state == S_FETCH) && b_live;
            py_v   <= (state == S_FETCH) && (k == '0);
            pa_row <= row_a; pa_col <= col_a;
            pb_row <= row_b; pb_col <= col_b;
            if (state == S_IDLE && start) begin
                cy <= CW'(LO); cx <= CW'(LO); cz <= CW'(LO);
                k  <= '0;
            end else if (state == S_FETCH) begin
                k <= KW'(k + 2);
            end else if (accept) begin
                k <= '0;
                if (int'(cz) == HI) begin
                    cz <= CW'(LO);
                    if (int'(cx) == HI) begin
                        cx <= CW'(LO);
                        cy <= CW'(cy + 1'b1);
                    end else begin
                        cx <= CW'(cx + 1'b1);
                    end
                end else begin
                    cz <= CW'(cz + 1'b1);
                end
            end
        end
    end

    svf_window #(.EXT(EXT), .RAD(RAD), .DW(DW), .CW(CW)) u_win (
        .clk(clk),
        .wa_en(pa_v), .wa_row(pa_row), .wa_col(pa_col),
        .wa_data(rd_data_a[int'(cy) * DW +: DW]),
        .wb_en(pb_v), .wb_row(pb_row), .wb_col(pb_col),
        .wb_data(rd_data_b[int'(cy) * DW +: DW]),
        .y_en(py_v), .y_data(y_data),
        .cx(cx), .cz(cz), .vec(out_vec)
    );

endmodule

// File: rtl/svf_chk.sv
module svf_chk #(
    parameter int EXT  = 32,
    parameter int RAD  = 4,
    parameter int NOPS = 25,
    parameter int DW   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [EXT-1:0]      rd_en_a,
    input logic [EXT-1:0]      rd_en_b,
    input logic                out_valid,
    input logic                out_ready,
    input logic [NOPS*DW-1:0]  out_vec,
    input logic                done
);
    // R7: vector held under backpressure
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_vec));

    // R7: no fetch while a vector waits
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rd_en_a == '0) && (rd_en_b == '0));

    // R8: completion is a single-cycle pulse
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: idle after completion
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !out_valid && (rd_en_a == '0) && (rd_en_b == '0));

    // R6: read spread limited to the stencil span; port B on one plane only
    p_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_en_a) <= 2 * RAD + 1);

    p_portb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_en_b));

    // R9: outputs quiet right after reset release
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !done);

endmodule

bind stencil_vec_feeder svf_chk #(
    .EXT(EXT), .RAD(RAD), .NOPS(6 * RAD + 1), .DW(DW)
) u_svf_chk (
    .clk(clk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec), .done(done)
);

// File: tb/tb_stencil_vec_feeder.sv
`timescale 1ns/1ps
module tb_stencil_vec_feeder;
    localparam int EXT  = 12;
    localparam int RAD  = 2;
    localparam int DW   = 16;
    localparam int CW   = $clog2(EXT);
    localparam int AW   = 2 * CW;
    localparam int W    = 2 * RAD + 1;
    localparam int NOPS = 6 * RAD + 1;
    localparam int LO   = RAD;
    localparam int HI   = EXT - 1 - RAD;

    logic clk = 1'b0;
    logic rst_n, start, out_ready, out_valid, done;
    logic [EXT-1:0] rd_en_a, rd_en_b;
    logic [EXT*AW-1:0] rd_addr_a, rd_addr_b;
    logic [EXT*DW-1:0] rd_data_a, rd_data_b;
    logic [NOPS*DW-1:0] out_vec;

    int checks = 0, fails = 0, dones = 0, rmode = 0;
    int rc [EXT];
    logic [NOPS*DW-1:0] exp_q [$];
    int crd_q [$];
    logic stall_prev = 1'b0, done_prev = 1'b0;
    logic [NOPS*DW-1:0] vec_prev;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    stencil_vec_feeder #(.EXT(EXT), .RAD(RAD), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec), .done(done)
    );

    function automatic logic [DW-1:0] val(input int p, input int r, input int c);
        return DW'(16'h5000 + p * 256 + r * 16 + c);
    endfunction

    function automatic int offs(input int i);
        return (i < RAD) ? (i - RAD) : (i - RAD + 1);
    endfunction

    // Plane memory model: registered read, data coded by position
    always @(posedge clk) begin
        for (int p = 0; p < EXT; p++) begin
            if (rd_en_a[p])
                rd_data_a[p*DW +: DW] <= val(p, int'(rd_addr_a[p*AW + CW +: CW]),
                                               int'(rd_addr_a[p*AW +: CW]));
            if (rd_en_b[p])
                rd_data_b[p*DW +: DW] <= val(p, int'(rd_addr_b[p*AW + CW +: CW]),
                                               int'(rd_addr_b[p*AW +: CW]));
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: push the expected vectors in R2 order
    task automatic push_expected();
        for (int y = LO; y <= HI; y++)
            for (int x = LO; x <= HI; x++)
                for (int z = LO; z <= HI; z++) begin
                    logic [NOPS*DW-1:0] v;
                    v = '0;
                    v[0 +: DW] = val(y, x, z);
                    for (int i = 0; i < 2 * RAD; i++) begin
                        v[(1 + i) * DW +: DW]           = val(y, x + offs(i), z);
                        v[(1 + 2 * RAD + i) * DW +: DW] = val(y + offs(i), x, z);
                        v[(1 + 4 * RAD + i) * DW +: DW] = val(y, x, z + offs(i));
                    end
                    exp_q.push_back(v);
                    crd_q.push_back((y << 16) | (x << 8) | z);
                end
    endtask

    // Ready pattern driver
    initial begin
        out_ready = 1'b0;
        forever begin
            @(posedge clk); #2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (rmode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < EXT; p++) rc[p] += int'(rd_en_a[p]) + int'(rd_en_b[p]);
            if (stall_prev) begin
                check(out_valid && out_vec == vec_prev, "R7", "held vector",
                      longint'(out_valid), 1);
            end
            if (done_prev) begin
                check(!done && !out_valid, "R8", "pulse width", longint'(done), 0);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "extra vector", 1, 0);
                end else begin
                    logic [NOPS*DW-1:0] e;
                    int c, y, x, z, want;
                    string tag;
                    e = exp_q.pop_front();
                    c = crd_q.pop_front();
                    y = c >> 16; x = (c >> 8) & 255; z = c & 255;
                    check(out_vec == e, "R1", "operands/order R2",
                          longint'(out_vec[0 +: DW]), longint'(e[0 +: DW]));
                    if (x == LO && z == LO) begin want = W * W; tag = "R3"; end
                    else if (x == LO)       begin want = W;     tag = "R4"; end
                    else if (z == LO)       begin want = W;     tag = "R5"; end
                    else                    begin want = 1;     tag = "R5"; end
                    check(rc[y] == want, tag, "centre-plane reads", rc[y], want);
                    for (int p = 0; p < EXT; p++) begin
                        if (p != y) begin
                            int wp;
                            wp = (p >= y - RAD && p <= y + RAD) ? 1 : 0;
                            check(rc[p] == wp, "R6", "other-plane reads", rc[p], wp);
                        end
                    end
                end
                for (int p = 0; p < EXT; p++) rc[p] = 0;
            end
            if (done) begin
                dones++;
                check(exp_q.size() == 0, "R8", "done before last vector",
                      exp_q.size(), 0);
            end
            stall_prev = out_valid && !out_ready;
            vec_prev   = out_vec;
            done_prev  = done;
        end
    end

    task automatic run_pass(input int m, output bit ok);
        int d0, cyc;
        rmode = m;
        push_expected();
        d0 = dones;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        cyc = 0;
        while (dones == d0 && cyc < 60000) begin
            @(negedge clk);
            cyc++;
        end
        ok = (dones != d0);
        check(ok, "R8", "pass completion (watchdog)", cyc, 0);
        check(exp_q.size() == 0, "R2", "vectors left over", exp_q.size(), 0);
        exp_q.delete();
        crd_q.delete();
    endtask

    initial begin
        bit ok;
        int tot;
        rd_data_a = '0; rd_data_b = '0;
        for (int p = 0; p < EXT; p++) rc[p] = 0;
        rst_n = 1'b0; start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(!out_valid && !done && rd_en_a == '0 && rd_en_b == '0, "R9",
              "reset outputs", longint'(out_valid), 0);
        #2 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid && rd_en_a == '0, "R9", "idle after reset",
              longint'(rd_en_a), 0);
        run_pass(0, ok);
        if (ok) begin
            repeat (12) @(negedge clk);
            tot = 0;
            for (int p = 0; p < EXT; p++) tot += rc[p];
            check(tot == 0 && !out_valid, "R8", "reads while idle", tot, 0);
            run_pass(1, ok);
        end
        check(dones == 2, "R8", "done pulse count", dones, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule